// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of one frequency-synthesizer loop, built in digital logic. A prescaler that divides by P or by P+1 is modelled as a counter running on the input clock. A swallow counter and a main counter steer its modulus-control line so that the whole chain emits one output pulse every P×B+A input clocks. The prescaler divides by P+1 for the first A prescaler periods of each output cycle and by P for the remaining B−A periods.

Software or a serial loader supplies the swallow value A, the main value B and the modulus select. A hold input models powerdown or counter reset. While hold is high, every counter sits in its load state and both outputs stay low. Counting resumes from the loaded values once hold is released. New settings are adopted only at a cycle boundary, so a cycle that is already in progress is never disturbed. The interface has no data stream: every pin is a plain control or status line and no back-pressure applies.

Top module: `swallow_divider`

## Requirements
- R1: While rst_n is low and in the clock after it, div_pulse and mod_ctrl are 0.
- R2: With hold low and a legal setting (3 ≤ B ≤ 2047, A ≤ B, A < P), consecutive div_pulse assertions are exactly P×B+A clocks apart. P is 64 when p_hi=0 and 128 when p_hi=1.
- R3: div_pulse is high for exactly one clock, and that clock is the last clock of each output cycle.
- R4: Within each output cycle, mod_ctrl is high for the first A×(P+1) clocks and low for the rest. With A=0 it never rises. With A=B it stays high for the whole cycle.
- R5: In the clock after any edge that samples hold high, both outputs are 0 and all counters are in their load state. Position 0 of a new cycle appears in the clock after the first edge that samples hold low again, so the first pulse shows in the N-th clock after that edge.
- R6: A change on a_val, b_val or p_hi in the middle of a cycle has no effect on that cycle. The change governs the cycle that starts after the next pulse.
- R7: The setting used after hold is released is the one sampled at the last edge with hold high. Values presented together with the release are not used until the next cycle boundary.
- R8: The internal prescaler count always stays below its current modulus (P or P+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | Powerdown / counter reset; forces the load state |
| a_val | input | 7 | Swallow count A (0..127) |
| b_val | input | 11 | Main count B (3..2047) |
| p_hi | input | 1 | Prescaler modulus select: 0 → 64/65, 1 → 128/129 |
| div_pulse | output | 1 | One-clock pulse at the end of every P×B+A clocks |
| mod_ctrl | output | 1 | Modulus control: 1 selects P+1, 0 selects P |

## Verification
Both outputs are decoded from registered state, so each one reflects the position reached after the most recent rising edge. A change on hold is therefore visible one clock later, and a new setting shows its effect one clock after the edge that closes the current cycle. The bench keeps a behavioural position counter that advances on the same edges. It compares both outputs against that counter at every falling edge, where inputs are held stable. Pulse-to-pulse gaps and the delay from hold release to the first pulse are also measured separately in clock counts.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int unsigned SWALLOW_W = 7;
  localparam int unsigned MAIN_W    = 11;
  localparam int unsigned MOD_LO    = 64;
  localparam int unsigned MOD_HI    = 128;
  localparam int unsigned MAIN_RST  = 3;

  function automatic int unsigned cnt_width(input int unsigned max_mod);
    return $clog2(max_mod + 2);
  endfunction
endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned MOD_LO = 64,
  parameter int unsigned MOD_HI = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            adv,
  input  logic            sel_hi,
  input  logic            plus_one,
  output logic            tick,
  output logic [PC_W-1:0] cnt_o,
  output logic [PC_W-1:0] mod_o
);
  localparam logic [PC_W-1:0] LO = PC_W'(MOD_LO);
  localparam logic [PC_W-1:0] HI = PC_W'(MOD_HI);

  logic [PC_W-1:0] cnt;
  logic [PC_W-1:0] modulus;

  always_comb begin
    modulus = (sel_hi ? HI : LO) + {{(PC_W-1){1'b0}}, plus_one};
    tick    = (cnt == (modulus - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= '0;
    else if (adv)   cnt <= tick ? '0 : cnt + 1'b1;
  end

  assign cnt_o = cnt;
  assign mod_o = modulus;
endmodule

// File: rtl/swdiv_downcount.sv
module swdiv_downcount #(
  parameter int unsigned W        = 7,
  parameter int unsigned RST_VAL  = 0,
  parameter bit          STOP_ZERO = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         nonzero,
  output logic         at_one
);
  logic [W-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n)        rem <= W'(RST_VAL);
    else if (load)     rem <= load_val;
    else if (step) begin
      if (STOP_ZERO) begin
        if (rem != '0) rem <= rem - 1'b1;
      end else begin
        rem <= rem - 1'b1;
      end
    end
  end

  assign nonzero = (rem != '0);
  assign at_one  = (rem == W'(1));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int unsigned A_W  = SWALLOW_W,
  parameter int unsigned B_W  = MAIN_W,
  parameter int unsigned P_LO = MOD_LO,
  parameter int unsigned P_HI = MOD_HI
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic           p_hi,
  output logic           div_pulse,
  output logic           mod_ctrl
);
  localparam int unsigned PC_W = cnt_width(P_HI);

  logic           running;
  logic           pre_tick;
  logic           sw_active;
  logic           main_last;
  logic           cycle_end;
  logic           load_all;
  logic           advance;
  logic           cfg_p_hi;
  logic [A_W-1:0] cfg_a;
  logic [B_W-1:0] cfg_b;
  logic [PC_W-1:0] pre_cnt;
  logic [PC_W-1:0] pre_mod;

  assign cycle_end = running && pre_tick && main_last;
  assign load_all  = hold || cycle_end;
  assign advance   = running && !hold;

  // run flag: first un-held edge only arms counting, so position 0 shows
  always_ff @(posedge clk) begin
    if (!rst_n)     running <= 1'b0;
    else if (hold)  running <= 1'b0;
    else            running <= 1'b1;
  end

  // setting shadow, adopted only at load points
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_p_hi <= 1'b0;
      cfg_a    <= '0;
      cfg_b    <= B_W'(MAIN_RST);
    end else if (load_all) begin
      cfg_p_hi <= p_hi;
      cfg_a    <= a_val;
      cfg_b    <= b_val;
    end
  end

  swdiv_prescaler #(.PC_W(PC_W), .MOD_LO(P_LO), .MOD_HI(P_HI)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_all),
    .adv      (advance),
    .sel_hi   (cfg_p_hi),
    .plus_one (sw_active),
    .tick     (pre_tick),
    .cnt_o    (pre_cnt),
    .mod_o    (pre_mod)
  );

  swdiv_downcount #(.W(A_W), .RST_VAL(0), .STOP_ZERO(1'b1)) u_swallow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_all),
    .load_val (a_val),
    .step     (advance && pre_tick),
    .nonzero  (sw_active),
    .at_one   ()
  );

  swdiv_downcount #(.W(B_W), .RST_VAL(MAIN_RST), .STOP_ZERO(1'b0)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_all),
    .load_val (b_val),
    .step     (advance && pre_tick),
    .nonzero  (),
    .at_one   (main_last)
  );

  assign div_pulse = cycle_end;
  assign mod_ctrl  = running && sw_active;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int unsigned A_W  = 7,
  parameter int unsigned B_W  = 11,
  parameter int unsigned PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold,
  input logic            div_pulse,
  input logic            mod_ctrl,
  input logic            running,
  input logic [PC_W-1:0] pre_cnt,
  input logic [PC_W-1:0] pre_mod,
  input logic            cfg_p_hi,
  input logic [A_W-1:0]  cfg_a,
  input logic [B_W-1:0]  cfg_b
);
  // R1: outputs quiet in the clock after a reset edge
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!div_pulse && !mod_ctrl));

  // R3: pulse never lasts two clocks
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R4: modulus control only rises at the start of a cycle
  assert_mod_rise_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_ctrl) |-> ($past(div_pulse) || !$past(running)));

  // R5: hold forces both outputs low on the next clock
  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!div_pulse && !mod_ctrl));

  // R6: adopted setting only changes at a load point
  assert_cfg_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(cfg_a) && $stable(cfg_b) && $stable(cfg_p_hi))
      |-> ($past(div_pulse) || $past(hold)));

  // R8: prescaler count below its modulus
  assert_pre_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt < pre_mod);
endmodule

bind swallow_divider swallow_divider_chk #(.A_W(A_W), .B_W(B_W), .PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold      (hold),
  .div_pulse (div_pulse),
  .mod_ctrl  (mod_ctrl),
  .running   (running),
  .pre_cnt   (pre_cnt),
  .pre_mod   (pre_mod),
  .cfg_p_hi  (cfg_p_hi),
  .cfg_a     (cfg_a),
  .cfg_b     (cfg_b)
);

// File: tb/swallow_divider_test.sv
`timescale 1ns/1ps
module swallow_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b1;
  logic [6:0]  a_val = '0;
  logic [10:0] b_val = 11'd3;
  logic        p_hi = 1'b0;
  logic        div_pulse;
  logic        mod_ctrl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  int m_run = 0, m_idx = 0, m_a = 0, m_b = 3, m_p = 64;

  always #10 clk = ~clk;

  swallow_divider uut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .a_val(a_val), .b_val(b_val),
    .p_hi(p_hi), .div_pulse(div_pulse), .mod_ctrl(mod_ctrl)
  );

  function automatic int nval(int a, int b, int p);
    return p * b + a;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_run = 0; m_idx = 0; m_a = 0; m_b = 3; m_p = 64;
    end else if (hold) begin
      m_run = 0; m_idx = 0;
      m_a = a_val; m_b = b_val; m_p = p_hi ? 128 : 64;
    end else if (m_run == 0) begin
      m_run = 1;
    end else if (m_idx == nval(m_a, m_b, m_p) - 1) begin
      m_idx = 0;
      m_a = a_val; m_b = b_val; m_p = p_hi ? 128 : 64;
    end else begin
      m_idx = m_idx + 1;
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int ep, em;
      ep = (m_run != 0 && m_idx == nval(m_a, m_b, m_p) - 1) ? 1 : 0;
      em = (m_run != 0 && m_idx < m_a * (m_p + 1)) ? 1 : 0;
      check((tag == "R4") ? "R3" : tag, int'(div_pulse), ep, "div_pulse vs model");
      check((tag == "R2" || tag == "R3") ? "R4" : tag, int'(mod_ctrl), em, "mod_ctrl vs model");
    end
  end

  task automatic wait_pulse(output int at);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!div_pulse && guard < 60000);
    at = cyc;
  endtask

  task automatic set_cfg(input int a, input int b, input bit ph);
    a_val = 7'(a); b_val = 11'(b); p_hi = ph;
  endtask

  task automatic start_run(input int a, input int b, input bit ph);
    @(negedge clk);
    hold = 1'b1;
    set_cfg(a, b, ph);
    @(negedge clk);
    @(negedge clk);
    hold = 1'b0;
  endtask

  task automatic gap_test(input string req, input int a, input int b, input bit ph);
    int t0, t1, t2;
    tag = req;
    start_run(a, b, ph);
    wait_pulse(t0);
    wait_pulse(t1);
    wait_pulse(t2);
    check(req, t1 - t0, nval(a, b, ph ? 128 : 64), "pulse gap 1");
    check(req, t2 - t1, nval(a, b, ph ? 128 : 64), "pulse gap 2");
  endtask

  initial begin
    int t0, t1, t2, cnt, hi_cnt;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", int'(div_pulse), 0, "div_pulse in reset");
    check("R1", int'(mod_ctrl), 0, "mod_ctrl in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(div_pulse), 0, "div_pulse after reset");

    // R2 several settings
    gap_test("R2", 5, 10, 1'b0);
    gap_test("R2", 0, 3, 1'b0);
    gap_test("R2", 17, 40, 1'b1);
    gap_test("R2", 127, 200, 1'b1);

    // R4: count mod_ctrl high clocks within one cycle, A=B case
    tag = "R4";
    start_run(63, 63, 1'b0);
    wait_pulse(t0);
    hi_cnt = 0;
    for (int i = 0; i < nval(63, 63, 64); i++) begin
      @(negedge clk);
      if (mod_ctrl) hi_cnt++;
    end
    check("R4", hi_cnt, 63 * 65, "mod_ctrl high clocks A=B");
    check("R3", int'(div_pulse), 1, "pulse on last clock");
    start_run(9, 12, 1'b0);
    wait_pulse(t0);
    hi_cnt = 0;
    for (int i = 0; i < nval(9, 12, 64); i++) begin
      @(negedge clk);
      if (mod_ctrl) hi_cnt++;
    end
    check("R4", hi_cnt, 9 * 65, "mod_ctrl high clocks A=9");

    // R5: hold mid-cycle, then release timing
    tag = "R5";
    start_run(4, 6, 1'b0);
    repeat (100) @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    check("R5", int'(mod_ctrl), 0, "mod_ctrl held");
    check("R5", int'(div_pulse), 0, "div_pulse held");
    hold = 1'b0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!div_pulse && cnt < 60000);
    check("R5", cnt, nval(4, 6, 64), "clocks from release to first pulse");

    // R7: values presented with the release are ignored
    tag = "R7";
    @(negedge clk);
    hold = 1'b1;
    set_cfg(3, 5, 1'b0);
    @(negedge clk);
    hold = 1'b0;
    set_cfg(20, 30, 1'b1);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!div_pulse && cnt < 60000);
    check("R7", cnt, nval(3, 5, 64), "release cycle uses held setting");
    wait_pulse(t1);
    wait_pulse(t2);
    check("R7", t2 - t1, nval(20, 30, 128), "later cycle uses new setting");

    // R6: change mid-cycle
    tag = "R6";
    start_run(2, 7, 1'b0);
    wait_pulse(t0);
    repeat (50) @(negedge clk);
    set_cfg(11, 20, 1'b1);
    wait_pulse(t1);
    wait_pulse(t2);
    check("R6", t1 - t0, nval(2, 7, 64), "current cycle unaffected");
    check("R6", t2 - t1, nval(11, 20, 128), "next cycle uses change");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    errors++;
    checks++;
    done = 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule